// File: doc/BRIEF.md
# Low-Power Mode Controller with External-Pin Wake-Up

This block decides when a small 8-bit core may run and when it sleeps. Software writes a 4-bit power control register. Bit 0 asks for a light sleep: the CPU clock stops while the timers, serial logic and interrupt logic keep their clock. Bit 1 asks for deep sleep: the oscillator is stopped as well. Bits 2 and 3 are free flags that software keeps across sleeps. Sleep starts at the end of the current instruction. While the block sleeps, no register or RAM state is lost.

Any enabled, pending interrupt ends a light sleep. Only the enabled external active-low interrupt lines end a deep sleep, and they do it in two steps. A low level turns the oscillator back on. The exit then completes once a line that went low is released and the oscillator reports that it is stable. At that point the block selects the wake interrupt with the highest priority, where line 0 ranks highest.

A qualified reset ends every state. Reset is accepted only after the reset input has been high for a set number of consecutive cycles, and it raises a flag that tells the core to reinitialise its special function registers. An exit through an interrupt leaves that flag low.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), the block is running. `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, `reg_rdata` is 0, `wake_sel` is 0 and `sfr_init` is 0.
- R2: A write (`reg_wr`) stores all 4 bits while the CPU clock is enabled, and `reg_rdata` shows them after the next edge. A write while the CPU clock is off is ignored. Bits 2 and 3 are never changed by hardware, except by an accepted reset.
- R3: With bit 0 set and bit 1 clear, an edge with `instr_done` high enters light sleep. After that edge `cpu_clk_en`=0 while `per_clk_en`=1 and `osc_en`=1.
- R4: In light sleep, an edge with any bit of `irq_pend` set returns the block to running. After that edge `cpu_clk_en`=1 and bit 0 of the register is 0.
- R5: With bit 1 set, an edge with `instr_done` high enters deep sleep, even if bit 0 is also set. After that edge `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R6: In deep sleep, `irq_pend`, register writes, and external lines that are low but whose `ext_en` bit is 0 have no effect. The block stays in deep sleep with `osc_en`=0.
- R7: In deep sleep, an edge at which an enabled external line is low (`ext_n[i]`=0 with `ext_en[i]`=1) sets `osc_en`=1 after it, and `cpu_clk_en` stays 0.
- R8: After that restart, the block returns to running at the first edge where a line seen low is high again and `osc_stable` is 1. The CPU clock stays off while either condition is missing. The exit clears bits 0 and 1.
- R9: On a deep-sleep exit through the pins, `wake_sel` becomes the one-hot code of the lowest-index line that was enabled and low at any edge from the restart through the exit edge (bit i stands for line i). It holds that value until the next deep-sleep entry or accepted reset, which set it to 0.
- R10: A reset is accepted at the RST_CYC-th consecutive edge with `rst_in` high. After that edge the block is running, `reg_rdata`=0, and `sfr_init`=1. `sfr_init` returns to 0 after the first edge with `rst_in` low. A shorter pulse changes neither the mode nor the register, and `sfr_init` stays 0.
- R11: In deep sleep, `osc_en` is 1 while `rst_in` is high, so that a reset has a running oscillator. An exit through the pins leaves `sfr_init` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_in | input | 1 | External reset request, qualified by length |
| reg_wr | input | 1 | Power control register write strobe |
| reg_wdata | input | 4 | Write data: bit 0 light sleep, bit 1 deep sleep, bits 3:2 flags |
| reg_rdata | output | 4 | Power control register contents |
| instr_done | input | 1 | Current instruction finishes this cycle |
| irq_pend | input | NIRQ | Enabled and pending interrupt requests |
| ext_n | input | NEXT | External interrupt pins, active low |
| ext_en | input | NEXT | Enable bits of the external interrupts |
| osc_stable | input | 1 | Oscillator has settled |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral and interrupt logic clock enable |
| osc_en | output | 1 | Oscillator run enable |
| wake_sel | output | NEXT | One-hot external interrupt chosen for service after deep-sleep exit |
| sfr_init | output | 1 | Core must reinitialise its special function registers |

## Verification
The bench builds the block with RST_CYC=24, NIRQ=4 and NEXT=2. With RST_CYC at 24, a 23-cycle reset pulse can be set against the full length at the exact acceptance boundary. The two external lines cover every priority case: both lines low, each line alone, the lower-priority line released first, and a disabled line held low next to an enabled one. Four request lines give enough distinct interrupt patterns to test the light-sleep wake.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {M_RUN, M_IDLE, M_PDOWN, M_RESTART} mode_e;
  localparam int PC_W    = 4;
  localparam int PC_IDLE = 0;
  localparam int PC_PD   = 1;
endpackage

// File: rtl/pm_rst_qual.sv
module pm_rst_qual #(
  parameter int RST_CYC = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_in,
  output logic rst_accept,
  output logic sfr_init
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

  logic [CW-1:0] cnt;

  // saturating run-length of consecutive high samples
  function automatic logic [CW-1:0] cnt_next(input logic hi, input logic [CW-1:0] c);
    if (!hi) return '0;
    return (c == LAST) ? c : c + 1'b1;
  endfunction

  assign rst_accept = rst_in && (cnt == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt      <= '0;
      sfr_init <= 1'b0;
    end else begin
      cnt <= cnt_next(rst_in, cnt);
      if (rst_accept)   sfr_init <= 1'b1;
      else if (!rst_in) sfr_init <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_wake_track.sv
module pm_wake_track
  import pwr_mode_pkg::*;
#(
  parameter int NEXT = 2
) (
  input  logic            clk,
  input  logic            por_n,
  input  mode_e           mode,
  input  logic [NEXT-1:0] ext_n,
  input  logic [NEXT-1:0] ext_en,
  input  logic            rst_accept,
  input  logic            pd_enter,
  input  logic            pd_exit,
  output logic            wake_start,
  output logic            released,
  output logic [NEXT-1:0] wake_sel
);
  logic [NEXT-1:0] lows, low_seen;
  logic            rel_seen, release_now;

  // lowest index wins
  function automatic logic [NEXT-1:0] prio_pick(input logic [NEXT-1:0] v);
    logic [NEXT-1:0] r;
    r = '0;
    for (int i = NEXT - 1; i >= 0; i--) if (v[i]) r = NEXT'(1) << i;
    return r;
  endfunction

  assign lows        = ext_en & ~ext_n;
  assign wake_start  = (mode == M_PDOWN) && (|lows);
  assign release_now = |(low_seen & ext_n);
  assign released    = rel_seen || release_now;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_seen <= '0;
      rel_seen <= 1'b0;
      wake_sel <= '0;
    end else if (rst_accept || pd_enter) begin
      low_seen <= '0;
      rel_seen <= 1'b0;
      wake_sel <= '0;
    end else if (wake_start) begin
      low_seen <= lows;
      rel_seen <= 1'b0;
    end else if (mode == M_RESTART) begin
      if (pd_exit) begin
        wake_sel <= prio_pick(low_seen | lows);
        low_seen <= '0;
        rel_seen <= 1'b0;
      end else begin
        low_seen <= low_seen | lows;
        rel_seen <= released;
      end
    end
  end
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic            clk,
  input  logic            por_n,
  input  logic            reg_wr,
  input  logic [PC_W-1:0] reg_wdata,
  input  logic            instr_done,
  input  logic            irq_any,
  input  logic            wake_start,
  input  logic            released,
  input  logic            osc_stable,
  input  logic            rst_accept,
  output mode_e           mode,
  output logic [PC_W-1:0] pcon,
  output logic            pd_enter,
  output logic            idle_enter,
  output logic            idle_wake,
  output logic            pd_exit
);
  function automatic logic [PC_W-1:0] clr_mode(input logic [PC_W-1:0] p, input logic both);
    logic [PC_W-1:0] r;
    r = p;
    r[PC_IDLE] = 1'b0;
    if (both) r[PC_PD] = 1'b0;
    return r;
  endfunction

  assign pd_enter   = (mode == M_RUN) && instr_done && pcon[PC_PD];
  assign idle_enter = (mode == M_RUN) && instr_done && pcon[PC_IDLE] && !pcon[PC_PD];
  assign idle_wake  = (mode == M_IDLE) && irq_any;
  assign pd_exit    = (mode == M_RESTART) && released && osc_stable;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode <= M_RUN;
      pcon <= '0;
    end else if (rst_accept) begin
      mode <= M_RUN;
      pcon <= '0;
    end else begin
      case (mode)
        M_RUN: begin
          if (pd_enter)        mode <= M_PDOWN;
          else if (idle_enter) mode <= M_IDLE;
          if (reg_wr) pcon <= reg_wdata;
        end
        M_IDLE: if (idle_wake) begin
          mode <= M_RUN;
          pcon <= clr_mode(pcon, 1'b0);
        end
        M_PDOWN: if (wake_start) mode <= M_RESTART;
        default: if (pd_exit) begin
          mode <= M_RUN;
          pcon <= clr_mode(pcon, 1'b1);
        end
      endcase
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int RST_CYC = 24,
  parameter int NIRQ    = 8,
  parameter int NEXT    = 2
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_in,
  input  logic            reg_wr,
  input  logic [PC_W-1:0] reg_wdata,
  output logic [PC_W-1:0] reg_rdata,
  input  logic            instr_done,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NEXT-1:0] ext_n,
  input  logic [NEXT-1:0] ext_en,
  input  logic            osc_stable,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            osc_en,
  output logic [NEXT-1:0] wake_sel,
  output logic            sfr_init
);
  mode_e mode;
  logic  rst_accept, wake_start, released;
  logic  pd_enter, idle_enter, idle_wake, pd_exit;

  pm_rst_qual #(.RST_CYC(RST_CYC)) u_rst (
    .clk(clk), .por_n(por_n), .rst_in(rst_in),
    .rst_accept(rst_accept), .sfr_init(sfr_init)
  );

  pm_wake_track #(.NEXT(NEXT)) u_wake (
    .clk(clk), .por_n(por_n), .mode(mode), .ext_n(ext_n), .ext_en(ext_en),
    .rst_accept(rst_accept), .pd_enter(pd_enter), .pd_exit(pd_exit),
    .wake_start(wake_start), .released(released), .wake_sel(wake_sel)
  );

  pm_mode_fsm u_fsm (
    .clk(clk), .por_n(por_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .instr_done(instr_done), .irq_any(|irq_pend), .wake_start(wake_start),
    .released(released), .osc_stable(osc_stable), .rst_accept(rst_accept),
    .mode(mode), .pcon(reg_rdata), .pd_enter(pd_enter), .idle_enter(idle_enter),
    .idle_wake(idle_wake), .pd_exit(pd_exit)
  );

  assign cpu_clk_en = (mode == M_RUN);
  assign per_clk_en = (mode == M_RUN) || (mode == M_IDLE);
  assign osc_en     = (mode != M_PDOWN) || rst_in;
endmodule

// File: rtl/pm_ctrl_chk.sv
module pm_ctrl_chk #(
  parameter int NIRQ = 8,
  parameter int NEXT = 2
) (
  input logic            clk,
  input logic            por_n,
  input logic            rst_in,
  input logic            instr_done,
  input logic [NIRQ-1:0] irq_pend,
  input logic [NEXT-1:0] ext_n,
  input logic [NEXT-1:0] ext_en,
  input logic            osc_stable,
  input logic            cpu_clk_en,
  input logic            per_clk_en,
  input logic            osc_en,
  input logic [NEXT-1:0] wake_sel,
  input logic            sfr_init,
  input logic [3:0]      reg_rdata,
  input logic            rst_accept
);
  a_r3_idle_entry: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_clk_en && instr_done && reg_rdata[0] && !reg_rdata[1] && !rst_accept)
      |=> (!cpu_clk_en && per_clk_en && osc_en));

  a_r4_idle_wake: assert property (@(posedge clk) disable iff (!por_n)
    (!cpu_clk_en && per_clk_en && (|irq_pend) && !rst_accept)
      |=> (cpu_clk_en && !reg_rdata[0]));

  a_r5_pd_entry: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_clk_en && instr_done && reg_rdata[1] && !rst_accept)
      |=> (!cpu_clk_en && !per_clk_en));

  a_r6_pd_holds: assert property (@(posedge clk) disable iff (!por_n)
    (!osc_en && !rst_in && !(|(ext_en & ~ext_n))) |=> !cpu_clk_en);

  a_r7_osc_restart: assert property (@(posedge clk) disable iff (!por_n)
    (!osc_en && (|(ext_en & ~ext_n))) |=> (osc_en && (sfr_init || !cpu_clk_en)));

  a_r8_exit_needs_stable: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(cpu_clk_en) && !$past(per_clk_en) && !$past(rst_accept)) |-> $past(osc_stable));

  a_r9_sel_onehot: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(wake_sel));

  a_r10_init_from_reset: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sfr_init) |-> ($past(rst_in) && reg_rdata == 4'd0 && cpu_clk_en));
endmodule

bind pwr_mode_ctrl pm_ctrl_chk #(.NIRQ(NIRQ), .NEXT(NEXT)) u_chk (.*);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int RC = 24;

  logic       clk = 1'b0, por_n = 1'b0, rst_in = 1'b0, reg_wr = 1'b0, instr_done = 1'b0;
  logic [3:0] reg_wdata = '0, reg_rdata, irq_pend = '0;
  logic [1:0] ext_n = 2'b11, ext_en = 2'b00, wake_sel;
  logic       osc_stable = 1'b1, cpu_clk_en, per_clk_en, osc_en, sfr_init;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_mode_ctrl #(.RST_CYC(RC), .NIRQ(4), .NEXT(2)) u_pwr_mode_ctrl (.*);

  function automatic logic [1:0] first_low(input logic [1:0] v);
    if (v[0]) return 2'b01;
    if (v[1]) return 2'b10;
    return 2'b00;
  endfunction

  // packs cpu,per,osc enables
  function automatic logic [2:0] en3(input logic c, input logic p, input logic o);
    return {c, p, o};
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] d);
    reg_wr = 1'b1; reg_wdata = d; cyc(); reg_wr = 1'b0;
  endtask

  task automatic go_sleep();
    instr_done = 1'b1; cyc(); instr_done = 1'b0;
  endtask

  task automatic pulse_rst(input int n);
    rst_in = 1'b1;
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] f, en, lo, dis;
    logic [3:0] irq;
    @(negedge clk); @(negedge clk);
    por_n = 1'b1; cyc();
    // R1
    chk("R1 enables", 8'(en3(cpu_clk_en, per_clk_en, osc_en)), 8'h7);
    chk("R1 reg", 8'(reg_rdata), 8'h0);
    chk("R1 sel/init", 8'({wake_sel, sfr_init}), 8'h0);

    // R2 + R3 + R4
    wr(4'b1101);
    chk("R2 write", 8'(reg_rdata), 8'hD);
    go_sleep();
    chk("R3 idle enables", 8'(en3(cpu_clk_en, per_clk_en, osc_en)), 8'h3);
    wr(4'b0000);
    chk("R2 write ignored in sleep", 8'(reg_rdata), 8'hD);
    irq_pend = 4'b0100; cyc(); irq_pend = '0;
    chk("R4 idle wake cpu", 8'(cpu_clk_en), 8'h1);
    chk("R4 idle bit cleared", 8'(reg_rdata), 8'hC);

    void'($urandom(32'd1234));
    for (int it = 0; it < 20; it++) begin
      f = 2'($urandom);
      irq = 4'($urandom_range(1, 15));
      wr({f, 2'b01});
      go_sleep();
      for (int w = 0; w < int'($urandom_range(0, 4)); w++) begin
        cyc();
        chk("R3 idle holds", 8'(cpu_clk_en), 8'h0);
      end
      irq_pend = irq; cyc(); irq_pend = '0;
      chk("R4 random wake", 8'({cpu_clk_en, reg_rdata}), 8'({1'b1, f, 2'b00}));
    end

    // R5 precedence, R6 ignored stimulus
    wr(4'b1011);
    go_sleep();
    chk("R5 pd enables", 8'(en3(cpu_clk_en, per_clk_en, osc_en)), 8'h0);
    irq_pend = 4'hF; cyc(); irq_pend = '0;
    chk("R6 irq ignored", 8'(en3(cpu_clk_en, per_clk_en, osc_en)), 8'h0);
    ext_en = 2'b00; ext_n = 2'b00; cyc();
    chk("R6 disabled pins ignored", 8'(osc_en), 8'h0);
    ext_n = 2'b11;
    wr(4'b0000);
    chk("R6 write ignored", 8'(reg_rdata), 8'hB);

    // R7, R8, R9 directed: line0 low, line1 low, line0 released before stable
    ext_en = 2'b11; osc_stable = 1'b0; ext_n = 2'b10; cyc();
    chk("R7 osc restart", 8'({osc_en, cpu_clk_en}), 8'h2);
    ext_n = 2'b00; cyc();
    ext_n = 2'b01; cyc();
    chk("R8 waits for stable", 8'(cpu_clk_en), 8'h0);
    osc_stable = 1'b1; cyc();
    chk("R8 exit", 8'({cpu_clk_en, reg_rdata}), 8'h18);
    chk("R9 priority both low", 8'(wake_sel), 8'h1);
    chk("R11 no init on pin exit", 8'(sfr_init), 8'h0);
    ext_n = 2'b11; cyc(); cyc();
    chk("R9 sel held", 8'(wake_sel), 8'h1);

    for (int it = 0; it < 20; it++) begin
      en  = 2'($urandom_range(1, 3));
      lo  = 2'($urandom) & en;
      if (lo == 2'b00) lo = en;
      dis = 2'($urandom) & ~en;
      ext_en = en;
      wr(4'b0010);
      go_sleep();
      chk("R9 cleared on pd entry", 8'(wake_sel), 8'h0);
      ext_n = ~(lo | dis);
      osc_stable = 1'($urandom);
      cyc();
      chk("R7 random restart", 8'({osc_en, cpu_clk_en}), 8'h2);
      for (int w = 0; w < int'($urandom_range(0, 3)); w++) begin
        osc_stable = 1'($urandom); cyc();
        chk("R8 held low stays asleep", 8'(cpu_clk_en), 8'h0);
      end
      ext_n = ~dis; osc_stable = 1'b1; cyc();
      chk("R8 random exit", 8'({cpu_clk_en, reg_rdata}), 8'h10);
      chk("R9 random sel", 8'(wake_sel), 8'(first_low(lo)));
      ext_n = 2'b11;
    end

    // R10 short and full reset during light sleep
    wr(4'b0101);
    go_sleep();
    pulse_rst(RC - 1); rst_in = 1'b0; cyc();
    chk("R10 short reset ignored", 8'({cpu_clk_en, sfr_init, reg_rdata}), 8'h05);
    pulse_rst(RC);
    chk("R10 reset accepted", 8'({cpu_clk_en, sfr_init, reg_rdata}), 8'h30);
    rst_in = 1'b0; cyc();
    chk("R10 init drops", 8'(sfr_init), 8'h0);

    // R11 reset from deep sleep
    ext_en = 2'b11;
    wr(4'b0010);
    go_sleep();
    chk("R11 pd entered", 8'(osc_en), 8'h0);
    pulse_rst(1);
    chk("R11 osc on during reset", 8'({osc_en, cpu_clk_en}), 8'h2);
    pulse_rst(RC - 1);
    chk("R10 pd reset exit", 8'({cpu_clk_en, sfr_init, reg_rdata}), 8'h30);
    chk("R10 sel cleared", 8'(wake_sel), 8'h0);
    rst_in = 1'b0; cyc();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule